// File: doc/BRIEF.md
# I2C Register Slave Interface

This block is an I2C slave that connects a two-wire control bus to a bank of 8-bit registers. The registers themselves live outside the block. The block filters and synchronises SCL and SDA into the system clock domain. It recognises START, repeated START and STOP, and it answers only to a fixed 7-bit device address. It drives SDA through an output enable, in the open-drain style, where a high enable pulls the line low.

The block keeps an internal byte pointer. In a write, the byte after the device address loads the pointer. Every later data byte is written to the register at the pointer, and the pointer then advances. A read returns the register at the current pointer and advances the pointer after each byte. This gives four kinds of transfer. A read with no new sub-address continues from where the last transfer stopped. A write of the sub-address, then a repeated START, then a read, gives a random read. A read keeps streaming bytes for as long as the host acknowledges. A write keeps storing bytes until the host sends a STOP.

The register bank is reached through a flat port. The block presents the pointer on `reg_addr`, a one-cycle write strobe with its data, and takes the read value combinationally on `reg_rdata`.

Top module: `i2c_reg_slave`

## Requirements
- R1: After synchronous reset, `sda_oe` is 0, `reg_we` is 0 and `reg_addr` is 0.
- R2: An SDA fall while SCL is high starts address matching from the next bit, even in the middle of a transfer (repeated START). An SDA rise while SCL is high ends the transfer. After either, `sda_oe` is 0.
- R3: A first byte whose upper seven bits equal 1000011 is acknowledged by holding SDA low through the 9th SCL pulse, and its lowest bit selects read (1) or write (0). Any other address gets no acknowledge. The bus is then ignored until the next START: no write strobe and no pointer change.
- R4: In a write, the byte after the device address is acknowledged and loads the pointer that `reg_addr` shows.
- R5: Each further write byte is acknowledged and produces exactly one `reg_we` pulse, with `reg_addr` set to the pointer and `reg_wdata` set to the byte. The pointer then increases by one and wraps from 0xFF to 0x00.
- R6: Read bytes leave the slave most significant bit first. Each bit is valid while SCL is high, and the pointer increases by one after each byte.
- R7: A read that is not preceded by a new sub-address returns the register at the pointer left by the previous transfer.
- R8: While the host acknowledges a read byte, the slave sends the next register. After a host not-acknowledge, the slave releases SDA and stays released until STOP or START.
- R9: `sda_oe` changes only while SCL is low, except for the release at START or STOP.
- R10: A pulse on SCL or SDA shorter than FILT_LEN system clock cycles has no effect on the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_addr | output | REG_AW | Register pointer |
| reg_wdata | output | 8 | Write data |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Data of the register at `reg_addr` |

## Verification
A START can arrive while the byte engine is partway through a transfer. In that case the START must win over any pending acknowledge or byte step. The bench provokes this by issuing a repeated START right after a data byte has been acknowledged, then writing to a fresh sub-address. It judges the outcome by the scoreboard: the second write must land at the new address with no stray strobe in between. The glitch filter and the edge detector also meet in one bit time. The bench injects short SCL and SDA pulses inside a written byte and requires the stored value to be unchanged.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DACK,
    ST_SUB,
    ST_SACK,
    ST_WR,
    ST_WACK,
    ST_RD,
    ST_RACK,
    ST_IGN
  } slv_state_t;
endpackage

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter #(
  parameter int FILT_LEN = 4,
  parameter bit RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync;
  logic [CW-1:0] cnt;

  // two-stage synchroniser, then a level must persist FILT_LEN cycles
  always_ff @(posedge clk) begin
    if (rst) begin
      sync <= {2{RST_VAL}};
      cnt  <= '0;
      dout <= RST_VAL;
    end else begin
      sync <= {sync[0], din};
      if (sync[1] == dout) begin
        cnt <= '0;
      end else if (cnt == CW'(FILT_LEN - 1)) begin
        dout <= sync[1];
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p,
  output logic sda_s
);
  logic scl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q    <= 1'b1;
      sda_s    <= 1'b1;
      scl_rise <= 1'b0;
      scl_fall <= 1'b0;
      start_p  <= 1'b0;
      stop_p   <= 1'b0;
    end else begin
      scl_q    <= scl;
      sda_s    <= sda;
      scl_rise <= scl & ~scl_q;
      scl_fall <= ~scl & scl_q;
      start_p  <= scl & scl_q & sda_s & ~sda;
      stop_p   <= scl & scl_q & ~sda_s & sda;
    end
  end
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_slv_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1000011,
  parameter int         REG_AW   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_p,
  input  logic              stop_p,
  input  logic              sda_s,
  input  logic [BYTE_W-1:0] reg_rdata,
  output logic              sda_oe,
  output logic [REG_AW-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we
);
  localparam logic [CNT_W-1:0] BIT_N = CNT_W'(BYTE_W);

  slv_state_t        st;
  logic [CNT_W-1:0]  bcnt;
  logic [BYTE_W-1:0] shr;
  logic [BYTE_W-1:0] txr;
  logic              rw;
  logic              mack;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      bcnt      <= '0;
      shr       <= '0;
      txr       <= '0;
      rw        <= 1'b0;
      mack      <= 1'b0;
      sda_oe    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_we    <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      if (reg_we) reg_addr <= reg_addr + 1'b1;

      if (start_p) begin
        st     <= ST_DEV;
        bcnt   <= '0;
        sda_oe <= 1'b0;
      end else if (stop_p) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_DEV, ST_SUB, ST_WR: begin
            if (scl_rise && bcnt != BIT_N) begin
              shr  <= {shr[BYTE_W-2:0], sda_s};
              bcnt <= bcnt + 1'b1;
            end else if (scl_fall && bcnt == BIT_N) begin
              bcnt <= '0;
              if (st == ST_DEV) begin
                if (shr[BYTE_W-1:1] == DEV_ADDR) begin
                  sda_oe <= 1'b1;
                  rw     <= shr[0];
                  st     <= ST_DACK;
                end else begin
                  st <= ST_IGN;
                end
              end else if (st == ST_SUB) begin
                reg_addr <= REG_AW'(shr);
                sda_oe   <= 1'b1;
                st       <= ST_SACK;
              end else begin
                reg_we    <= 1'b1;
                reg_wdata <= shr;
                sda_oe    <= 1'b1;
                st        <= ST_WACK;
              end
            end
          end
          ST_DACK: begin
            if (scl_fall) begin
              if (rw) begin
                txr    <= reg_rdata;
                sda_oe <= ~reg_rdata[BYTE_W-1];
                st     <= ST_RD;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_SUB;
              end
            end
          end
          ST_SACK, ST_WACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              st     <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              if (bcnt == BIT_N - 1'b1) begin
                sda_oe   <= 1'b0;
                bcnt     <= '0;
                reg_addr <= reg_addr + 1'b1;
                st       <= ST_RACK;
              end else begin
                bcnt   <= bcnt + 1'b1;
                txr    <= {txr[BYTE_W-2:0], 1'b0};
                sda_oe <= ~txr[BYTE_W-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                txr    <= reg_rdata;
                sda_oe <= ~reg_rdata[BYTE_W-1];
                st     <= ST_RD;
              end else begin
                st <= ST_IGN;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_slv_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1000011,
  parameter int         FILT_LEN = 4,
  parameter int         REG_AW   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [REG_AW-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [BYTE_W-1:0] reg_rdata
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw_lines;
  logic [LINES-1:0] flt_lines;
  logic scl_rise, scl_fall, start_p, stop_p, sda_s;

  assign raw_lines = {sda_i, scl_i};

  genvar gi;
  generate
    for (gi = 0; gi < LINES; gi++) begin : g_filt
      i2c_glitch_filter #(.FILT_LEN(FILT_LEN), .RST_VAL(1'b1)) u_filt (
        .clk (clk),
        .rst (rst),
        .din (raw_lines[gi]),
        .dout(flt_lines[gi])
      );
    end
  endgenerate

  i2c_bus_events u_evt (
    .clk     (clk),
    .rst     (rst),
    .scl     (flt_lines[0]),
    .sda     (flt_lines[1]),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_p (start_p),
    .stop_p  (stop_p),
    .sda_s   (sda_s)
  );

  i2c_slave_fsm #(.DEV_ADDR(DEV_ADDR), .REG_AW(REG_AW)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_p  (start_p),
    .stop_p   (stop_p),
    .sda_s    (sda_s),
    .reg_rdata(reg_rdata),
    .sda_oe   (sda_oe),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_we   (reg_we)
  );
endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk #(
  parameter int REG_AW = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_i,
  input logic              sda_oe,
  input logic              start_p,
  input logic              stop_p,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_addr
);
  // R1: outputs are quiet on the first cycle out of reset
  p_rst_quiet_r1: assert property (@(posedge clk) $fell(rst) |-> (!sda_oe && !reg_we && reg_addr == '0));

  // R2: START or STOP always leaves SDA released
  p_cond_release_r2: assert property (@(posedge clk) disable iff (rst) (start_p || stop_p) |=> !sda_oe);

  // R5: a write strobe lasts one cycle
  p_we_single_r5: assert property (@(posedge clk) disable iff (rst) reg_we |=> !reg_we);

  // R5: the pointer steps by one after each write
  p_ptr_step_r5: assert property (@(posedge clk) disable iff (rst) reg_we |=> (reg_addr == $past(reg_addr) + 1'b1));

  // R9: the SDA driver moves only while SCL is low, or on START/STOP
  p_oe_scl_low_r9: assert property (@(posedge clk) disable iff (rst) !$stable(sda_oe) |-> (!scl_i || $past(start_p || stop_p)));
endmodule

bind i2c_reg_slave i2c_reg_slave_chk #(.REG_AW(REG_AW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .scl_i   (scl_i),
  .sda_oe  (sda_oe),
  .start_p (start_p),
  .stop_p  (stop_p),
  .reg_we  (reg_we),
  .reg_addr(reg_addr)
);

// File: tb/i2c_reg_slave_test.sv
`timescale 1ns/1ps
module i2c_reg_slave_test;
  localparam int QTR = 20;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1, g_scl = 1'b0, g_sda = 1'b0;
  logic       sda_oe, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;

  wire scl_w = m_scl | g_scl;
  wire sda_w = m_sda & ~g_sda & ~sda_oe;

  i2c_reg_slave uut (
    .clk(clk), .rst(rst), .scl_i(scl_w), .sda_i(sda_w), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  function automatic logic [7:0] seed(int i);
    return 8'((i * 29) ^ 8'h5A);
  endfunction

  // register bank model
  logic [7:0] mem [0:255];
  logic [7:0] exp_mem [0:255];
  assign reg_rdata = mem[reg_addr];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= seed(i);
    end else if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
    end
  end

  int checks = 0, fails = 0;
  logic [15:0] wq [$];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic void push_wr(input logic [7:0] a, input logic [7:0] d);
    wq.push_back({a, d});
    exp_mem[a] = d;
  endfunction

  // monitor: pops expected writes as strobes appear
  always @(negedge clk) begin
    if (!rst && reg_we) begin
      if (wq.size() == 0) begin
        chk(1'b0, "R5", "unexpected write strobe at addr", int'(reg_addr), 0);
      end else begin
        logic [15:0] e;
        e = wq.pop_front();
        chk(reg_addr == e[15:8], "R5", "write addr", int'(reg_addr), int'(e[15:8]));
        chk(reg_wdata == e[7:0], "R5", "write data", int'(reg_wdata), int'(e[7:0]));
      end
    end
  end

  task automatic q();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; q();
    m_scl = 1'b1; q();
    m_sda = 1'b0; q();
    m_scl = 1'b0; q();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; q();
    m_scl = 1'b1; q();
    m_sda = 1'b1; q();
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i];
      if (glitch && i == 3) begin
        repeat (5) @(negedge clk);
        g_scl = 1'b1; repeat (2) @(negedge clk); g_scl = 1'b0;
        repeat (QTR - 7) @(negedge clk);
      end else begin
        q();
      end
      m_scl = 1'b1;
      q();
      if (glitch && i == 7) begin
        repeat (4) @(negedge clk);
        g_sda = 1'b1; repeat (2) @(negedge clk); g_sda = 1'b0;
        repeat (QTR - 6) @(negedge clk);
      end else begin
        q();
      end
      m_scl = 1'b0; q();
    end
    m_sda = 1'b1; q();
    m_scl = 1'b1; q();
    ack = ~sda_w; q();
    m_scl = 1'b0; q();
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q();
      m_scl = 1'b1; q();
      b[i] = sda_w; q();
      m_scl = 1'b0;
    end
    q();
    m_sda = ~give_ack; q();
    m_scl = 1'b1; q(); q();
    m_scl = 1'b0;
    m_sda = 1'b1; q();
  endtask

  localparam logic [7:0] DEV_W = 8'h86;
  localparam logic [7:0] DEV_R = 8'h87;

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "ALL", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] rb;
    for (int i = 0; i < 256; i++) exp_mem[i] = seed(i);
    repeat (10) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(sda_oe == 1'b0, "R1", "sda_oe after reset", int'(sda_oe), 0);
    chk(reg_we == 1'b0, "R1", "reg_we after reset", int'(reg_we), 0);
    chk(reg_addr == 8'h00, "R1", "reg_addr after reset", int'(reg_addr), 0);
    q();

    // multi-byte write at 0x10 (R3, R4, R5)
    push_wr(8'h10, 8'hA5); push_wr(8'h11, 8'h3C); push_wr(8'h12, 8'hF0);
    bus_start();
    send_byte(DEV_W, 1'b0, ack); chk(ack, "R3", "ack of matching address", int'(ack), 1);
    send_byte(8'h10, 1'b0, ack); chk(ack, "R4", "ack of sub-address", int'(ack), 1);
    chk(reg_addr == 8'h10, "R4", "pointer loaded", int'(reg_addr), 'h10);
    send_byte(8'hA5, 1'b0, ack); chk(ack, "R5", "ack data 0", int'(ack), 1);
    send_byte(8'h3C, 1'b0, ack); chk(ack, "R5", "ack data 1", int'(ack), 1);
    send_byte(8'hF0, 1'b0, ack); chk(ack, "R5", "ack data 2", int'(ack), 1);
    bus_stop();
    chk(reg_addr == 8'h13, "R5", "pointer after writes", int'(reg_addr), 'h13);
    chk(sda_oe == 1'b0, "R2", "released after STOP", int'(sda_oe), 0);

    // random sequential read through repeated START (R2, R6, R8)
    bus_start();
    send_byte(DEV_W, 1'b0, ack);
    send_byte(8'h10, 1'b0, ack);
    bus_start();
    send_byte(DEV_R, 1'b0, ack); chk(ack, "R2", "ack after repeated START read", int'(ack), 1);
    recv_byte(1'b1, rb); chk(rb == exp_mem[8'h10], "R6", "read byte 0", int'(rb), int'(exp_mem[8'h10]));
    recv_byte(1'b1, rb); chk(rb == exp_mem[8'h11], "R8", "read byte 1 after ack", int'(rb), int'(exp_mem[8'h11]));
    recv_byte(1'b0, rb); chk(rb == exp_mem[8'h12], "R8", "read byte 2", int'(rb), int'(exp_mem[8'h12]));
    chk(sda_oe == 1'b0, "R8", "released after NACK", int'(sda_oe), 0);
    q();
    chk(sda_oe == 1'b0, "R8", "still released before STOP", int'(sda_oe), 0);
    bus_stop();
    chk(reg_addr == 8'h13, "R6", "pointer after three reads", int'(reg_addr), 'h13);

    // current-address read (R7)
    bus_start();
    send_byte(DEV_R, 1'b0, ack);
    recv_byte(1'b0, rb); chk(rb == exp_mem[8'h13], "R7", "current-address read", int'(rb), int'(exp_mem[8'h13]));
    bus_stop();

    // wrong address is ignored (R3)
    bus_start();
    send_byte(8'h8C, 1'b0, ack); chk(!ack, "R3", "no ack on wrong address", int'(ack), 0);
    send_byte(8'h77, 1'b0, ack); chk(!ack, "R3", "no ack while ignoring", int'(ack), 0);
    bus_stop();
    bus_start();
    send_byte(DEV_R, 1'b0, ack);
    recv_byte(1'b0, rb); chk(rb == exp_mem[8'h14], "R3", "pointer untouched by foreign transfer", int'(rb), int'(exp_mem[8'h14]));
    bus_stop();

    // repeated START inside a write (R2)
    push_wr(8'h40, 8'h11); push_wr(8'h50, 8'h22);
    bus_start();
    send_byte(DEV_W, 1'b0, ack);
    send_byte(8'h40, 1'b0, ack);
    send_byte(8'h11, 1'b0, ack);
    bus_start();
    send_byte(DEV_W, 1'b0, ack); chk(ack, "R2", "ack after repeated START in write", int'(ack), 1);
    send_byte(8'h50, 1'b0, ack);
    send_byte(8'h22, 1'b0, ack);
    bus_stop();
    chk(reg_addr == 8'h51, "R2", "pointer after restarted write", int'(reg_addr), 'h51);

    // glitches on both lines inside a written byte (R10)
    push_wr(8'h60, 8'h96);
    bus_start();
    send_byte(DEV_W, 1'b0, ack);
    send_byte(8'h60, 1'b0, ack);
    send_byte(8'h96, 1'b1, ack); chk(ack, "R10", "ack of glitched byte", int'(ack), 1);
    bus_stop();
    chk(reg_addr == 8'h61, "R10", "single write despite glitches", int'(reg_addr), 'h61);

    // pointer wrap (R5)
    push_wr(8'hFF, 8'h1E); push_wr(8'h00, 8'hE1);
    bus_start();
    send_byte(DEV_W, 1'b0, ack);
    send_byte(8'hFF, 1'b0, ack);
    send_byte(8'h1E, 1'b0, ack);
    send_byte(8'hE1, 1'b0, ack);
    bus_stop();
    chk(reg_addr == 8'h01, "R5", "pointer wrapped", int'(reg_addr), 'h01);
    chk(wq.size() == 0, "R5", "all expected writes seen", wq.size(), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule